// File: doc/BRIEF.md
# Power supply protection supervisor

This block is the digital supervisor of an off-line flyback controller. It decides, cycle by cycle, whether the switching stage may run. It takes already-digitised comparator flags as inputs: three supply-level flags (start level, run level, keep-alive level), a supply over-voltage flag, a feedback-saturated flag and an output over-voltage flag from the detect winding. It also takes the present gate drive state. From these it produces a PWM enable, a soft-start ramp code for the current-limit reference, and a sticky fault flag.

The supply levels give a hysteresis window. Switching starts at the start level and stops at the run level. The fault latch only forgets its state below the keep-alive level. Supply over-voltage and feedback saturation are auto-recovering faults. Each is debounced, stops switching, and is forgotten once the supply sags through the run level, so the normal discharge and recharge hiccup restarts the converter. Output over-voltage is only looked at while the gate is low and a blanking interval after turn-off has passed, so the ringing after turn-off is ignored. Once debounced, it sets the sticky fault, which survives every hiccup until the supply collapses completely. Every time switching is allowed again, the soft-start code restarts from zero and climbs to full scale.

All time limits are parameters counted in clock cycles. All flag inputs are plain levels, with no handshake. The reset is asynchronous and active low and models power-on.

Top module: `psu_guard`

## Requirements
- R1: After reset, pwm_en_o is 0, ss_code_o is 0 and latch_fault_o is 0.
- R2: From the idle state, with latch_fault_o low, a high vdd_start_i at a clock edge makes pwm_en_o 1 from the next cycle on.
- R3: While enabled, a low vdd_run_i at a clock edge makes pwm_en_o 0 from the next cycle. It then stays 0 even after vdd_run_i returns high, until vdd_start_i is high again.
- R4: While enabled, vdd_ov_i high on SUPPLY_OV_CYC consecutive edges makes pwm_en_o 0 on the next cycle. pwm_en_o then stays 0 even with vdd_start_i high, until vdd_run_i has been low; after that, a high vdd_start_i restarts as in R2.
- R5: While enabled, fb_high_i high on OPEN_LOOP_CYC consecutive edges stops switching and recovers exactly as in R4.
- R6: Each debounce count restarts from zero when its condition is absent on any edge, so shorter bursts never trip, however often they repeat.
- R7: out_ov_i is sampled only at edges where gate_i is low and the gate has been low for more than BLANK_CYC edges since its last fall. When it is high on OUT_OV_CYC consecutive sampled edges while enabled, latch_fault_o becomes 1 and pwm_en_o becomes 0 on the next cycle. An unsampled edge restarts the count.
- R8: latch_fault_o stays 1, and pwm_en_o stays 0, through any run-level and start-level activity while vdd_alive_i is high. A low vdd_alive_i clears it on the next cycle, and vdd_start_i then restarts normally.
- R9: ss_code_o is 0 whenever the block was not enabled in the previous cycle. While enabled, it rises by one every SS_STEP_CYC enabled cycles and saturates at all ones. After n enabled edges it equals min(n / SS_STEP_CYC, 2^SS_W - 1).
- R10: When the output over-voltage trip and an auto-recovering trip occur on the same edge, the sticky fault wins: latch_fault_o becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| vdd_start_i | input | 1 | Supply above the start level |
| vdd_run_i | input | 1 | Supply above the run level |
| vdd_alive_i | input | 1 | Supply above the keep-alive level |
| vdd_ov_i | input | 1 | Supply over-voltage comparator |
| fb_high_i | input | 1 | Feedback above the open-loop level |
| out_ov_i | input | 1 | Detect-input over-voltage comparator |
| gate_i | input | 1 | Present gate drive state, 1 = switch on |
| pwm_en_o | output | 1 | Switching permitted |
| ss_code_o | output | SS_W | Soft-start ramp code for the current limit |
| latch_fault_o | output | 1 | Sticky output over-voltage fault |

## Verification
Two trips can land on the same edge: the sticky output over-voltage trip and the auto-recovering open-loop trip. The bench provokes this by raising the feedback flag a fixed number of cycles before the gate falls with the detect flag high. That lead is chosen so that both debounce windows close on the same edge once blanking is counted in. The outcome is judged by latch_fault_o rising with pwm_en_o dropping. After that, the start level is held high and switching is expected to stay off through a run-level dip, which a plain hiccup would not do.

// File: rtl/psu_guard_pkg.sv
package psu_guard_pkg;

  typedef enum logic [1:0] {
    SUP_IDLE   = 2'd0,
    SUP_RUN    = 2'd1,
    SUP_HICCUP = 2'd2
  } sup_state_e;

  localparam int unsigned TRIP_SUPPLY_OV = 0;
  localparam int unsigned TRIP_OPEN_LOOP = 1;
  localparam int unsigned TRIP_OUT_OV    = 2;
  localparam int unsigned N_TRIP         = 3;

endpackage

// File: rtl/psu_guard_debounce.sv
module psu_guard_debounce #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic trip_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign trip_o = cond_i && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/psu_guard_blank.sv
module psu_guard_blank #(
  parameter int unsigned BLANK_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic sample_ok_o
);
  localparam int unsigned BW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC + 1) : 1;

  logic          gate_q;
  logic [BW-1:0] hold_q;
  logic          fall;

  assign fall = gate_q && !gate_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      hold_q <= '0;
    end else begin
      gate_q <= gate_i;
      if (fall) begin
        hold_q <= BW'(BLANK_CYC - 1);
      end else if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end
    end
  end

  assign sample_ok_o = !gate_i && !fall && (hold_q == '0);

endmodule

// File: rtl/psu_guard_softstart.sv
module psu_guard_softstart #(
  parameter int unsigned SS_W     = 8,
  parameter int unsigned STEP_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  output logic [SS_W-1:0] code_o
);
  localparam int unsigned PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [PW-1:0]   presc_q;
  logic [SS_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      code_q  <= '0;
    end else if (!run_i) begin
      presc_q <= '0;
      code_q  <= '0;
    end else if (presc_q == PW'(STEP_CYC - 1)) begin
      presc_q <= '0;
      if (code_q != '1) code_q <= code_q + 1'b1;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/psu_guard.sv
module psu_guard
  import psu_guard_pkg::*;
#(
  parameter int unsigned SUPPLY_OV_CYC = 150,
  parameter int unsigned OPEN_LOOP_CYC = 55000,
  parameter int unsigned OUT_OV_CYC    = 200,
  parameter int unsigned BLANK_CYC     = 4,
  parameter int unsigned SS_STEP_CYC   = 8,
  parameter int unsigned SS_W          = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vdd_start_i,
  input  logic            vdd_run_i,
  input  logic            vdd_alive_i,
  input  logic            vdd_ov_i,
  input  logic            fb_high_i,
  input  logic            out_ov_i,
  input  logic            gate_i,
  output logic            pwm_en_o,
  output logic [SS_W-1:0] ss_code_o,
  output logic            latch_fault_o
);

  localparam int unsigned TRIP_LIM [N_TRIP] = '{SUPPLY_OV_CYC, OPEN_LOOP_CYC, OUT_OV_CYC};

  sup_state_e        state_q, state_d;
  logic              latch_q, latch_d;
  logic              running;
  logic              sample_ok;
  logic [N_TRIP-1:0] cond;
  logic [N_TRIP-1:0] trip;
  logic              auto_trip;

  assign running = (state_q == SUP_RUN);

  psu_guard_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_i     (gate_i),
    .sample_ok_o(sample_ok)
  );

  assign cond[TRIP_SUPPLY_OV] = running && vdd_ov_i;
  assign cond[TRIP_OPEN_LOOP] = running && fb_high_i;
  assign cond[TRIP_OUT_OV]    = running && out_ov_i && sample_ok;

  for (genvar g = 0; g < N_TRIP; g++) begin : g_deb
    psu_guard_debounce #(.LIMIT(TRIP_LIM[g])) u_deb (
      .clk   (clk),
      .rst_n (rst_n),
      .cond_i(cond[g]),
      .trip_o(trip[g])
    );
  end

  assign auto_trip = trip[TRIP_SUPPLY_OV] || trip[TRIP_OPEN_LOOP];

  always_comb begin
    latch_d = latch_q;
    if (!vdd_alive_i) latch_d = 1'b0;
    else if (trip[TRIP_OUT_OV]) latch_d = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SUP_IDLE:   if (vdd_start_i && !latch_q) state_d = SUP_RUN;
      SUP_RUN: begin
        if (!vdd_run_i || trip[TRIP_OUT_OV]) state_d = SUP_IDLE;
        else if (auto_trip)                  state_d = SUP_HICCUP;
      end
      SUP_HICCUP: if (!vdd_run_i) state_d = SUP_IDLE;
      default:    state_d = SUP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SUP_IDLE;
      latch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      latch_q <= latch_d;
    end
  end

  psu_guard_softstart #(.SS_W(SS_W), .STEP_CYC(SS_STEP_CYC)) u_ss (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (running),
    .code_o(ss_code_o)
  );

  assign pwm_en_o      = running;
  assign latch_fault_o = latch_q;

endmodule

// File: rtl/psu_guard_checker.sv
module psu_guard_checker #(
  parameter int unsigned SS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vdd_run_i,
  input logic            vdd_alive_i,
  input logic            pwm_en_o,
  input logic [SS_W-1:0] ss_code_o,
  input logic            latch_fault_o
);

  AST_LATCH_BLOCKS_PWM: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fault_o |-> !pwm_en_o); // R7

  AST_RUN_LOSS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en_o && !vdd_run_i |=> !pwm_en_o); // R3

  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    latch_fault_o && vdd_alive_i |=> latch_fault_o); // R8

  AST_LATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_alive_i |=> !latch_fault_o); // R8

  AST_SS_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_en_o |=> ss_code_o == '0); // R9

  AST_SS_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en_o) |-> ss_code_o == '0); // R9

  AST_SS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_en_o |=> ({1'b0, ss_code_o} == {1'b0, $past(ss_code_o)}) ||
                 ({1'b0, ss_code_o} == {1'b0, $past(ss_code_o)} + 1'b1)); // R9

endmodule

bind psu_guard psu_guard_checker #(.SS_W(SS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vdd_run_i    (vdd_run_i),
  .vdd_alive_i  (vdd_alive_i),
  .pwm_en_o     (pwm_en_o),
  .ss_code_o    (ss_code_o),
  .latch_fault_o(latch_fault_o)
);

// File: tb/test_psu_guard.sv
module test_psu_guard;

  localparam int OV_N    = 5;
  localparam int OL_N    = 12;
  localparam int DET_N   = 4;
  localparam int BLANK_N = 3;
  localparam int STEP_N  = 2;
  localparam int SSW     = 4;
  localparam int SS_MAX  = (1 << SSW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vdd_start_i = 0, vdd_run_i = 0, vdd_alive_i = 0;
  logic vdd_ov_i = 0, fb_high_i = 0, out_ov_i = 0, gate_i = 0;
  logic           pwm_en_o;
  logic [SSW-1:0] ss_code_o;
  logic           latch_fault_o;

  always #4 clk = ~clk;

  psu_guard #(
    .SUPPLY_OV_CYC(OV_N), .OPEN_LOOP_CYC(OL_N), .OUT_OV_CYC(DET_N),
    .BLANK_CYC(BLANK_N), .SS_STEP_CYC(STEP_N), .SS_W(SSW)
  ) i_psu_guard (
    .clk(clk), .rst_n(rst_n),
    .vdd_start_i(vdd_start_i), .vdd_run_i(vdd_run_i), .vdd_alive_i(vdd_alive_i),
    .vdd_ov_i(vdd_ov_i), .fb_high_i(fb_high_i), .out_ov_i(out_ov_i), .gate_i(gate_i),
    .pwm_en_o(pwm_en_o), .ss_code_o(ss_code_o), .latch_fault_o(latch_fault_o)
  );

  // behavioural reference: 0 idle, 1 switching, 2 waiting for supply sag
  int m_mode = 0, m_latch = 0;
  int n_ov = 0, n_ol = 0, n_det = 0;
  int low_len = BLANK_N;
  int on_edges = 0;
  int compared = 0, mismatched = 0;
  bit finished = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_latch = 0; n_ov = 0; n_ol = 0; n_det = 0;
      low_len = BLANK_N; on_edges = 0;
    end else begin
      int  nxt_mode, nxt_latch, cur_low;
      bit  sw, seen, t_ov, t_ol, t_det;
      sw = (m_mode == 1);
      cur_low = gate_i ? 0 : low_len + 1;
      seen = !gate_i && (cur_low > BLANK_N);
      t_ov  = sw && vdd_ov_i && (n_ov + 1 >= OV_N);
      t_ol  = sw && fb_high_i && (n_ol + 1 >= OL_N);
      t_det = sw && out_ov_i && seen && (n_det + 1 >= DET_N);
      n_ov  = (sw && vdd_ov_i) ? n_ov + 1 : 0;
      n_ol  = (sw && fb_high_i) ? n_ol + 1 : 0;
      n_det = (sw && out_ov_i && seen) ? n_det + 1 : 0;
      low_len = (cur_low > 1000) ? 1000 : cur_low;
      nxt_latch = !vdd_alive_i ? 0 : (t_det ? 1 : m_latch);
      nxt_mode = m_mode;
      if (m_mode == 0) begin
        if (vdd_start_i && m_latch == 0) nxt_mode = 1;
      end else if (m_mode == 1) begin
        if (!vdd_run_i || t_det) nxt_mode = 0;
        else if (t_ov || t_ol)   nxt_mode = 2;
      end else begin
        if (!vdd_run_i) nxt_mode = 0;
      end
      on_edges = sw ? on_edges + 1 : 0;
      m_mode = nxt_mode;
      m_latch = nxt_latch;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      int exp_en, exp_ss, exp_lf;
      exp_en = (m_mode == 1) ? 1 : 0;
      exp_ss = (on_edges / STEP_N > SS_MAX) ? SS_MAX : on_edges / STEP_N;
      exp_lf = m_latch;
      compared++;
      if (pwm_en_o !== exp_en[0] || ss_code_o !== exp_ss[SSW-1:0] || latch_fault_o !== exp_lf[0]) begin
        mismatched++;
        $display("FAIL %s t=%0t en=%0b/%0d ss=%0d/%0d latch=%0b/%0d (actual/expected)",
                 tag, $time, pwm_en_o, exp_en, ss_code_o, exp_ss, latch_fault_o, exp_lf);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sag_and_restart();
    vdd_start_i = 0; vdd_run_i = 0; step(2);
    vdd_alive_i = 0; step(2);
    vdd_alive_i = 1; vdd_run_i = 1; step(2);
    vdd_start_i = 1; step(5);
  endtask

  initial begin
    step(3);
    rst_n = 1; step(2);

    tag = "R2";
    vdd_alive_i = 1; step(2);
    vdd_run_i = 1; step(2);
    vdd_start_i = 1; step(6);

    tag = "R9";
    step(30);

    tag = "R3";
    vdd_start_i = 0; step(3);
    vdd_run_i = 0; step(3);
    vdd_run_i = 1; step(4);
    vdd_start_i = 1; step(5);

    tag = "R6";
    for (int i = 0; i < 3; i++) begin
      vdd_ov_i = 1; step(OV_N - 1);
      vdd_ov_i = 0; step(1);
    end
    fb_high_i = 1; step(OL_N - 1);
    fb_high_i = 0; step(2);

    tag = "R4";
    vdd_ov_i = 1; step(OV_N + 3);
    vdd_ov_i = 0; step(4);
    sag_and_restart();

    tag = "R5";
    fb_high_i = 1; step(OL_N + 3);
    fb_high_i = 0; step(3);
    vdd_start_i = 0; vdd_run_i = 0; step(2);
    vdd_run_i = 1; vdd_start_i = 1; step(6);

    tag = "R7";
    out_ov_i = 1;
    gate_i = 1; step(2);
    gate_i = 0; step(BLANK_N);
    gate_i = 1; step(2);
    gate_i = 0; step(BLANK_N + 2);
    gate_i = 1; step(2);
    gate_i = 0; step(BLANK_N + DET_N + 2);
    gate_i = 1; step(3);

    tag = "R8";
    vdd_start_i = 0; vdd_run_i = 0; step(3);
    vdd_run_i = 1; vdd_start_i = 1; step(4);
    out_ov_i = 0;
    vdd_start_i = 0; vdd_run_i = 0; vdd_alive_i = 0; step(2);
    vdd_alive_i = 1; vdd_run_i = 1; step(1);
    vdd_start_i = 1; step(6);

    tag = "R10";
    gate_i = 1; fb_high_i = 1; step(OL_N - DET_N - BLANK_N);
    gate_i = 0; out_ov_i = 1; step(BLANK_N + DET_N + 3);
    fb_high_i = 0; out_ov_i = 0; step(2);
    vdd_run_i = 0; step(2);
    vdd_run_i = 1; step(3);
    sag_and_restart();

    step(2);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog expired during %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule